// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block produces the readout timing for a linear CCD image sensor from a host FPGA clock. When a start request arrives while the sensor reports a stored frame, it raises the read line for one read pulse. It then holds the line low for the correlated double-sampling interval. After that it toggles the read line once per pixel clock until the frame is exhausted. The number of read clocks comes from a two-pin window/binning selection. The selection is captured when the start request is accepted. Three extra clocks at the head of every frame fill the sensor's output pipeline and carry no pixel data.

For each data-carrying clock the sequencer strobes an external ADC in the last low cycle of that clock. That cycle sits right before the next rising edge of the read line, which is when the sensor's analog output has settled. One cycle later it reports the sample as a valid pixel with its 10-bit index. It stops early if the sensor flags the last pixel. It records whether the sensor still holds another frame. A rising edge on the clear input drops the readout at once.

Top module: `lread_seq`

## Requirements
- R1: After an accepted start, `rd_o` is high for exactly PULSE_W cycles and then low for exactly CDS_WAIT cycles before the first read clock rises.
- R2: A frame has (active + 3) read clocks. `roi_i`=0 selects the full line and `roi_i`=1 selects half of it. `bin_i`=2'b01 gives no binning, 2'b00 gives binning by 2, and 2'b10 or 2'b11 give binning by 4. So the active counts are 512/1024/256/256 for roi 0 and 256/512/128/128 for roi 1.
- R3: Every read clock is high for CLK_HI cycles and low for CLK_LO cycles.
- R4: The first three read clocks of a frame produce no `adc_stb_o`. Every later clock produces one `adc_stb_o` in its last low cycle, directly followed by a rising `rd_o` or by `done_o`.
- R5: `pix_vld_o` follows each `adc_stb_o` by one cycle. `pix_idx_o` runs 0,1,2,... without gaps within a frame.
- R6: `done_o` is a one-cycle pulse in the same cycle as the final `pix_vld_o`, and `busy_o` is low from that cycle on.
- R7: A start request is ignored while `drdy_i` is low or while a frame is in progress.
- R8: When `last_i` is high at the end of a data-carrying clock, the frame ends after that pixel.
- R9: `nomore_o` takes the inverse of `drdy_i` at the end of the first read clock and holds it until the next accepted start.
- R10: A rising edge on `clr_i` aborts the frame. From the next cycle `busy_o` and `rd_o` are low, and no further strobe or `done_o` follows.
- R11: Changes of `roi_i`/`bin_i` after the start is accepted do not change the running frame's clock count.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Readout start request |
| roi_i | input | 1 | Window select (0 full, 1 half) |
| bin_i | input | 2 | Binning select |
| clr_i | input | 1 | Clear request, rising edge aborts |
| drdy_i | input | 1 | Sensor reports a stored frame |
| last_i | input | 1 | Sensor flags the last pixel |
| rd_o | output | 1 | Read pulse / read clock to sensor |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame completed pulse |
| adc_stb_o | output | 1 | ADC capture strobe |
| pix_vld_o | output | 1 | Pixel sample valid |
| pix_idx_o | output | 10 | Index of the valid pixel |
| nomore_o | output | 1 | No further frame stored behind this one |

## Verification
On every cycle the assertions check four things. The read line must not rise for the first clock before the double-sampling wait has elapsed. Each ADC strobe must be in a low phase, followed by a read edge or completion, and answered by a pixel-valid. Completion and abort must leave the block idle, and starts refused for lack of data must leave it idle too. Only the bench scenarios can show the full clock count for each of the eight window/binning codes, the unbroken pixel index order, the early stop on the last-pixel flag, and the capture of the no-more-frames flag. They also show that configuration changes in mid-frame change nothing.

// File: rtl/lread_pkg.sv
package lread_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PULSE,
    PH_CDS,
    PH_HI,
    PH_LO
  } phase_t;

  localparam int unsigned PRELOAD = 3;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lread_cfg.sv
module lread_cfg
  import lread_pkg::*;
#(
  parameter int unsigned NPIX = 1024,
  parameter int unsigned CW   = $clog2(NPIX + PRELOAD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          roi_i,
  input  logic [1:0]    bin_i,
  output logic [CW-1:0] last_clk
);

  logic [CW-1:0] last_q, last_nx;
  int unsigned   shift;

  always_comb begin
    case (bin_i)
      2'b00:   shift = 1;
      2'b01:   shift = 0;
      default: shift = 2;
    endcase
    if (roi_i) shift = shift + 1;
    last_nx = last_q;
    if (load) last_nx = CW'((NPIX >> shift) + PRELOAD - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_nx;
  end

  assign last_clk = last_q;

endmodule

// File: rtl/lread_phase.sv
module lread_phase
  import lread_pkg::*;
#(
  parameter int unsigned PULSE_W  = 4,
  parameter int unsigned CDS_WAIT = 8,
  parameter int unsigned CLK_HI   = 2,
  parameter int unsigned CLK_LO   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic drdy_i,
  input  logic clr_i,
  input  logic stop,
  output logic go,
  output logic abort,
  output logic period_end,
  output logic rd_o,
  output logic busy_o
);

  localparam int unsigned MAXT = max4(PULSE_W, CDS_WAIT, CLK_HI, CLK_LO);
  localparam int unsigned TW   = (MAXT < 2) ? 1 : $clog2(MAXT);

  phase_t        st_q, st_nx;
  logic [TW-1:0] tmr_q, tmr_nx;
  logic          clr_q;
  logic          rd_q, rd_nx;

  assign abort      = clr_i & ~clr_q;
  assign go         = (st_q == PH_IDLE) & start_i & drdy_i & ~abort;
  assign period_end = (st_q == PH_LO) & (tmr_q == '0);

  always_comb begin
    st_nx  = st_q;
    tmr_nx = tmr_q;
    if (tmr_q != '0) tmr_nx = tmr_q - 1'b1;
    if (abort) begin
      st_nx  = PH_IDLE;
      tmr_nx = '0;
    end else begin
      case (st_q)
        PH_IDLE: if (go) begin
          st_nx  = PH_PULSE;
          tmr_nx = TW'(PULSE_W - 1);
        end
        PH_PULSE: if (tmr_q == '0) begin
          st_nx  = PH_CDS;
          tmr_nx = TW'(CDS_WAIT - 1);
        end
        PH_CDS: if (tmr_q == '0) begin
          st_nx  = PH_HI;
          tmr_nx = TW'(CLK_HI - 1);
        end
        PH_HI: if (tmr_q == '0) begin
          st_nx  = PH_LO;
          tmr_nx = TW'(CLK_LO - 1);
        end
        PH_LO: if (tmr_q == '0) begin
          if (stop) begin
            st_nx  = PH_IDLE;
          end else begin
            st_nx  = PH_HI;
            tmr_nx = TW'(CLK_HI - 1);
          end
        end
        default: st_nx = PH_IDLE;
      endcase
    end
    rd_nx = (st_nx == PH_PULSE) | (st_nx == PH_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      tmr_q <= '0;
      clr_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_nx;
      tmr_q <= tmr_nx;
      clr_q <= clr_i;
      rd_q  <= rd_nx;
    end
  end

  assign rd_o   = rd_q;
  assign busy_o = (st_q != PH_IDLE);

endmodule

// File: rtl/lread_pix.sv
module lread_pix
  import lread_pkg::*;
#(
  parameter int unsigned NPIX = 1024,
  parameter int unsigned CW   = $clog2(NPIX + PRELOAD),
  parameter int unsigned IW   = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  logic          period_end,
  input  logic [CW-1:0] last_clk,
  input  logic          last_i,
  input  logic          drdy_i,
  output logic          stop,
  output logic          adc_stb_o,
  output logic          pix_vld_o,
  output logic [IW-1:0] pix_idx_o,
  output logic          done_o,
  output logic          nomore_o
);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [IW-1:0] idx_q, idx_nx;
  logic          vld_q, vld_nx;
  logic          done_q, done_nx;
  logic          nom_q, nom_nx;
  logic          preload;

  assign preload   = (cnt_q < CW'(PRELOAD));
  assign adc_stb_o = period_end & ~preload;
  assign stop      = period_end & ((cnt_q == last_clk) | (~preload & last_i));

  always_comb begin
    cnt_nx  = cnt_q;
    idx_nx  = idx_q;
    nom_nx  = nom_q;
    vld_nx  = adc_stb_o & ~abort;
    done_nx = stop & ~abort;
    if (go) begin
      cnt_nx = '0;
      nom_nx = 1'b0;
    end else if (period_end & ~abort) begin
      cnt_nx = cnt_q + 1'b1;
      if (cnt_q == '0) nom_nx = ~drdy_i;
    end
    if (adc_stb_o & ~abort) idx_nx = IW'(cnt_q - CW'(PRELOAD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      nom_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      idx_q  <= idx_nx;
      vld_q  <= vld_nx;
      done_q <= done_nx;
      nom_q  <= nom_nx;
    end
  end

  assign pix_vld_o = vld_q;
  assign pix_idx_o = idx_q;
  assign done_o    = done_q;
  assign nomore_o  = nom_q;

endmodule

// File: rtl/lread_seq.sv
module lread_seq
  import lread_pkg::*;
#(
  parameter int unsigned NPIX     = 1024,
  parameter int unsigned PULSE_W  = 4,
  parameter int unsigned CDS_WAIT = 8,
  parameter int unsigned CLK_HI   = 2,
  parameter int unsigned CLK_LO   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       roi_i,
  input  logic [1:0] bin_i,
  input  logic       clr_i,
  input  logic       drdy_i,
  input  logic       last_i,
  output logic       rd_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       adc_stb_o,
  output logic       pix_vld_o,
  output logic [9:0] pix_idx_o,
  output logic       nomore_o
);

  localparam int unsigned CW = $clog2(NPIX + PRELOAD);
  localparam int unsigned IW = $clog2(NPIX);

  logic          go_w;
  logic          abort_w;
  logic          pend_w;
  logic          stop_w;
  logic [CW-1:0] last_clk_w;
  logic [IW-1:0] idx_w;

  lread_cfg #(.NPIX(NPIX), .CW(CW)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go_w),
    .roi_i    (roi_i),
    .bin_i    (bin_i),
    .last_clk (last_clk_w)
  );

  lread_phase #(
    .PULSE_W (PULSE_W),
    .CDS_WAIT(CDS_WAIT),
    .CLK_HI  (CLK_HI),
    .CLK_LO  (CLK_LO)
  ) i_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .drdy_i     (drdy_i),
    .clr_i      (clr_i),
    .stop       (stop_w),
    .go         (go_w),
    .abort      (abort_w),
    .period_end (pend_w),
    .rd_o       (rd_o),
    .busy_o     (busy_o)
  );

  lread_pix #(.NPIX(NPIX), .CW(CW), .IW(IW)) i_pix (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go_w),
    .abort      (abort_w),
    .period_end (pend_w),
    .last_clk   (last_clk_w),
    .last_i     (last_i),
    .drdy_i     (drdy_i),
    .stop       (stop_w),
    .adc_stb_o  (adc_stb_o),
    .pix_vld_o  (pix_vld_o),
    .pix_idx_o  (idx_w),
    .done_o     (done_o),
    .nomore_o   (nomore_o)
  );

  assign pix_idx_o = 10'(idx_w);

endmodule

// File: rtl/lread_chk.sv
module lread_chk #(
  parameter int unsigned CDS_WAIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic rd_o,
  input logic adc_stb_o,
  input logic pix_vld_o,
  input logic done_o,
  input logic busy_o,
  input logic start_i,
  input logic drdy_i,
  input logic go,
  input logic abort
);

  logic        rd_d;
  logic [1:0]  rises;
  logic [15:0] lowc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d  <= 1'b0;
      rises <= 2'd0;
      lowc  <= 16'd0;
    end else begin
      rd_d <= rd_o;
      if (go) rises <= 2'd0;
      else if (rd_o && !rd_d && rises != 2'd3) rises <= rises + 2'd1;
      if (rd_o) lowc <= 16'd0;
      else if (lowc != 16'hffff) lowc <= lowc + 16'd1;
    end
  end

  assert_cds_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && !rd_d && rises == 2'd1) |-> (lowc >= 16'(CDS_WAIT)));

  assert_strobe_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb_o |-> !rd_o);

  assert_strobe_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_stb_o && !abort) |=> (rd_o || done_o));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_stb_o && !abort) |=> pix_vld_o);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && pix_vld_o));

  assert_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !drdy_i) |=> !busy_o);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_o && !rd_o && !done_o));

endmodule

bind lread_seq lread_chk #(.CDS_WAIT(CDS_WAIT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_o      (rd_o),
  .adc_stb_o (adc_stb_o),
  .pix_vld_o (pix_vld_o),
  .done_o    (done_o),
  .busy_o    (busy_o),
  .start_i   (start_i),
  .drdy_i    (drdy_i),
  .go        (go_w),
  .abort     (abort_w)
);

// File: tb/test_lread_seq.sv
module test_lread_seq;

  localparam int PULSE_W  = 3;
  localparam int CDS_WAIT = 5;
  localparam int CLK_HI   = 2;
  localparam int CLK_LO   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       roi_i = 1'b0;
  logic [1:0] bin_i = 2'b00;
  logic       clr_i = 1'b0;
  logic       drdy_i = 1'b0;
  logic       last_i = 1'b0;
  logic       rd_o, busy_o, done_o, adc_stb_o, pix_vld_o, nomore_o;
  logic [9:0] pix_idx_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lread_seq #(
    .NPIX(1024), .PULSE_W(PULSE_W), .CDS_WAIT(CDS_WAIT),
    .CLK_HI(CLK_HI), .CLK_LO(CLK_LO)
  ) i_lread_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .roi_i(roi_i), .bin_i(bin_i),
    .clr_i(clr_i), .drdy_i(drdy_i), .last_i(last_i), .rd_o(rd_o), .busy_o(busy_o),
    .done_o(done_o), .adc_stb_o(adc_stb_o), .pix_vld_o(pix_vld_o),
    .pix_idx_o(pix_idx_o), .nomore_o(nomore_o)
  );

  // monitor and sensor model state
  int  rises, hirun, lowrun, pulse_len, cds_len, hi_bad, lo_bad;
  int  adc_cnt, adc_bad, adc_pos_bad, vld_cnt, idx_bad, done_cnt, done_bad;
  int  frames_left, last_rise;
  bit  rd_prev, adc_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; hirun = 0; lowrun = 0; pulse_len = 0; cds_len = 0;
    hi_bad = 0; lo_bad = 0; adc_cnt = 0; adc_bad = 0; adc_pos_bad = 0;
    vld_cnt = 0; idx_bad = 0; done_cnt = 0; done_bad = 0;
    rd_prev = 0; adc_prev = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_o && !rd_prev) begin
        rises++;
        if (rises == 2) cds_len = lowrun;
        else if (rises >= 3 && lowrun != CLK_LO) lo_bad++;
        if (rises == 2 && frames_left == 1) drdy_i = 1'b0;
        last_i = (rises == last_rise);
      end
      if (!rd_o && rd_prev) begin
        if (rises == 1) pulse_len = hirun;
        else if (hirun != CLK_HI) hi_bad++;
      end
      if (adc_prev && !(rd_o && !rd_prev) && !done_o) adc_pos_bad++;
      if (adc_stb_o) begin
        adc_cnt++;
        if (rd_o) adc_bad++;
      end
      if (pix_vld_o) begin
        if (pix_idx_o != 10'(vld_cnt)) idx_bad++;
        if (!adc_prev) idx_bad++;
        vld_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        if (!pix_vld_o) done_bad++;
      end
      if (rd_o) begin hirun++; lowrun = 0; end
      else begin lowrun++; hirun = 0; end
      rd_prev = rd_o;
      adc_prev = adc_stb_o;
    end
  end

  function automatic int active_of(input int r, input int b);
    int sh;
    sh = (b == 0) ? 1 : (b == 1) ? 0 : 2;
    return 1024 >> (sh + r);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_frame(input int r, input int b, input int frames,
                           input int lrise, input int exp_pix, input bit restart,
                           input string tag);
    @(posedge clk);
    clear_mon();
    frames_left = frames;
    last_rise = lrise;
    last_i = 1'b0;
    roi_i = r[0];
    bin_i = b[1:0];
    drdy_i = (frames > 0);
    pulse_start();
    // R11: scramble configuration after acceptance
    roi_i = ~r[0];
    bin_i = b[1:0] + 2'd1;
    if (restart) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    for (int w = 0; w < 8000 && busy_o; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(vld_cnt == exp_pix, {"R2/R11 pixel count ", tag}, vld_cnt, exp_pix);
    chk(rises == exp_pix + 4, {"R2 read edges ", tag}, rises, exp_pix + 4);
    chk(pulse_len == PULSE_W, {"R1 pulse width ", tag}, pulse_len, PULSE_W);
    chk(cds_len == CDS_WAIT, {"R1 cds wait ", tag}, cds_len, CDS_WAIT);
    chk(hi_bad == 0 && lo_bad == 0, {"R3 clock phases ", tag}, hi_bad + lo_bad, 0);
    chk(adc_cnt == exp_pix && adc_bad == 0 && adc_pos_bad == 0,
        {"R4 adc strobes ", tag}, adc_cnt, exp_pix);
    chk(idx_bad == 0, {"R5 index order ", tag}, idx_bad, 0);
    chk(done_cnt == 1 && done_bad == 0, {"R6 done pulse ", tag}, done_cnt, 1);
    if (restart) chk(rises == exp_pix + 4, {"R7 start while busy ", tag}, rises, exp_pix + 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mon();
    frames_left = 0;
    last_rise = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk({rd_o, busy_o, done_o, adc_stb_o, pix_vld_o, nomore_o} == 6'b0 && pix_idx_o == 10'd0,
        "R12 reset outputs", int'({rd_o, busy_o, done_o, adc_stb_o, pix_vld_o, nomore_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 sweep over every window/binning code
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 4; b++) begin
        int n;
        n = active_of(r, b);
        run_frame(r, b, 2, n + 4, n, (r == 0 && b == 0), $sformatf("roi%0d bin%0d", r, b));
        chk(nomore_o == 1'b0, "R9 frame still stored", int'(nomore_o), 0);
      end
    end

    // R9: last stored frame, data-ready drops on first clock
    run_frame(1, 2, 1, 132, 128, 0, "single frame");
    chk(nomore_o == 1'b1, "R9 no more frames", int'(nomore_o), 1);

    // R7: start with no stored frame
    clear_mon();
    drdy_i = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b0 && rises == 0, "R7 start without data", rises, 0);
    chk(nomore_o == 1'b1, "R9 flag held after refused start", int'(nomore_o), 1);

    // R8: early end on last-pixel flag at pixel 40 (read edge 45)
    run_frame(1, 2, 2, 45, 41, 0, "early last");

    // R10: abort mid-frame
    @(posedge clk);
    clear_mon();
    frames_left = 2; last_rise = 0; last_i = 1'b0;
    roi_i = 1'b1; bin_i = 2'b00; drdy_i = 1'b1;
    pulse_start();
    for (int w = 0; w < 2000 && vld_cnt < 10; w++) @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && rd_o == 1'b0, "R10 abort idles", int'({busy_o, rd_o}), 0);
    begin
      int rs, vs;
      rs = rises; vs = vld_cnt;
      repeat (100) @(negedge clk);
      chk(rises == rs && vld_cnt == vs, "R10 no activity after abort", rises + vld_cnt, rs + vs);
      chk(done_cnt == 0, "R10 no done after abort", done_cnt, 0);
    end
    clr_i = 1'b0;
    repeat (2) @(negedge clk);

    // recovery after abort
    run_frame(0, 2, 2, 260, 256, 0, "after abort");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule